// File: doc/BRIEF.md
# Daisy-Chain Interrupt Acknowledge Logic

This block models a row of device interface slices that share one interrupt request line toward a processor. Each slice keeps a pending-request bit and owns a fixed 8-bit identification byte. Any slice with a pending bit raises the shared request. When the processor answers with an acknowledge level, the acknowledge enters slice 0, the slice nearest the processor, and travels slice by slice toward the far end. The first pending slice it meets takes it, places its identification byte on the data bus with an output enable, and stops the acknowledge from going further. A slice with nothing pending hands the acknowledge on unchanged.

If the acknowledge reaches the far end untaken, nobody drives the bus and a no-claimant flag is raised instead. The slice that was serviced drops its pending bit once the acknowledge is withdrawn. Requests that arrive while an acknowledge is active are parked and only become pending after it ends, so the winner and the byte on the bus cannot change partway through an acknowledge. The chain length can be set from 2 to 16 slices, and each slice's identification byte is a parameter.

Top module: `irq_chain`

## Requirements
- R1: `irqOut` is high in every cycle that at least one slice is pending; a slice becomes pending at the first rising clock edge at which its `reqIn` bit is high while `ackIn` is low.
- R2: While `ackIn` is high and some slice is pending, `idDrive` is high in the same cycle and `idBus` carries the identification byte of the pending slice with the lowest index. Slice i's byte sits at bits [8*i+7 : 8*i] of the `SLICE_IDS` parameter.
- R3: Priority depends only on position: a pending slice with a higher index has no effect on `idBus` while any lower-indexed slice is pending. A non-pending slice lets the acknowledge pass unchanged.
- R4: While `ackIn` is high and no slice is pending, `idDrive` is low, `idBus` is 0 and `noClaim` is high.
- R5: At most one slice claims the acknowledge in any cycle.
- R6: After a cycle with `ackIn` high, the first rising edge with `ackIn` low clears the pending bit of the slice that was serviced. Every other pending bit keeps its value.
- R7: A `reqIn` bit that is high while `ackIn` is high changes neither `irqOut`, `idBus` nor `idDrive` during that acknowledge. It becomes pending at the first rising edge with `ackIn` low.
- R8: While `ackIn` is low, `idDrive` and `noClaim` are low and `idBus` is 0.
- R9: While `rst_n` is low, all pending and parked requests are cleared, so `irqOut` is low after reset.
- R10: If a new request for the serviced slice arrives on the same edge that would clear it, the slice stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SLICES | Per-slice request inputs; bit 0 is the slice nearest the processor |
| ackIn | input | 1 | Interrupt acknowledge level from the processor |
| irqOut | output | 1 | Shared request line, OR of all pending bits |
| idBus | output | ID_W | Identification byte of the claiming slice, 0 when nobody drives |
| idDrive | output | 1 | Output enable for `idBus` |
| noClaim | output | 1 | The acknowledge passed the last slice untaken |

## Verification
The acknowledge path has no registers, so `idBus`, `idDrive` and `noClaim` are due in the same cycle that `ackIn` rises. The bench drives inputs on the falling edge and samples one nanosecond later, before any rising edge. Pending bits, clearing and parked requests take effect one rising edge after their cause, so those results are sampled after the following falling edge. The bench sweeps every pending pattern of a four-slice chain and services each pattern down to empty. It computes the expected winner as the lowest set bit of a mask it tracks itself.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  // Strobes sent from the control sequencer to the chain datapath.
  typedef struct packed {
    logic holdNew;        // acknowledge active: park incoming requests
    logic captureGrant;   // remember which slice took the acknowledge
    logic clearServiced;  // acknowledge just ended: retire the served slice
  } chainStrobes_t;
endpackage

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
  import irq_chain_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ackIn,
  output chainStrobes_t strobes
);
  logic ackPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) ackPrev <= 1'b0;
    else        ackPrev <= ackIn;
  end

  always_comb begin
    strobes.holdNew       = ackIn;
    strobes.captureGrant  = ackIn;
    strobes.clearServiced = ackPrev & ~ackIn;
  end
endmodule

// File: rtl/irq_chain_dp.sv
module irq_chain_dp
  import irq_chain_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int ID_W       = 8,
  parameter logic [NUM_SLICES*ID_W-1:0] SLICE_IDS = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] reqIn,
  input  logic                  ackIn,
  input  chainStrobes_t         strobes,
  output logic [NUM_SLICES-1:0] pending,
  output logic [NUM_SLICES-1:0] grantVec,
  output logic [ID_W-1:0]       idBus,
  output logic                  chainTail
);
  localparam int LinkCnt = NUM_SLICES + 1;

  logic [NUM_SLICES-1:0] deferred;
  logic [NUM_SLICES-1:0] grantHeld;
  logic [NUM_SLICES-1:0] retireMask;
  logic [LinkCnt-1:0]    ackLink;
  logic [ID_W-1:0]       idTerm [NUM_SLICES];

  assign ackLink[0] = ackIn;

  // One slice per stage: claim on a pending bit, otherwise pass the acknowledge on.
  for (genvar gi = 0; gi < NUM_SLICES; gi++) begin : g_slice
    assign grantVec[gi]    = ackLink[gi] & pending[gi];
    assign ackLink[gi + 1] = ackLink[gi] & ~pending[gi];
    assign idTerm[gi]      = grantVec[gi] ? SLICE_IDS[gi*ID_W +: ID_W] : '0;
  end

  assign chainTail = ackLink[NUM_SLICES];

  // The grant vector is one-hot or empty, so an OR merge is the bus driver.
  always_comb begin
    idBus = '0;
    for (int k = 0; k < NUM_SLICES; k++) idBus = idBus | idTerm[k];
  end

  assign retireMask = strobes.clearServiced ? grantHeld : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending   <= '0;
      deferred  <= '0;
      grantHeld <= '0;
    end else begin
      if (strobes.captureGrant) grantHeld <= grantVec;
      if (strobes.holdNew) begin
        deferred <= deferred | reqIn;
      end else begin
        // New requests win over the retire of the served slice.
        pending  <= (pending & ~retireMask) | reqIn | deferred;
        deferred <= '0;
      end
    end
  end
endmodule

// File: rtl/irq_chain.sv
module irq_chain
  import irq_chain_pkg::*;
#(
  parameter int NUM_SLICES = 4,
  parameter int ID_W       = 8,
  parameter logic [NUM_SLICES*ID_W-1:0] SLICE_IDS = 32'hE8_17_5C_A3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SLICES-1:0] reqIn,
  input  logic                  ackIn,
  output logic                  irqOut,
  output logic [ID_W-1:0]       idBus,
  output logic                  idDrive,
  output logic                  noClaim
);
  chainStrobes_t         strobes;
  logic [NUM_SLICES-1:0] pending;
  logic [NUM_SLICES-1:0] grantVec;
  logic                  chainTail;

  irq_chain_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ackIn   (ackIn),
    .strobes (strobes)
  );

  irq_chain_dp #(
    .NUM_SLICES (NUM_SLICES),
    .ID_W       (ID_W),
    .SLICE_IDS  (SLICE_IDS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqIn     (reqIn),
    .ackIn     (ackIn),
    .strobes   (strobes),
    .pending   (pending),
    .grantVec  (grantVec),
    .idBus     (idBus),
    .chainTail (chainTail)
  );

  assign irqOut  = |pending;
  assign idDrive = |grantVec;
  assign noClaim = chainTail;
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk #(
  parameter int NUM_SLICES = 4,
  parameter int ID_W       = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ackIn,
  input logic                  irqOut,
  input logic [ID_W-1:0]       idBus,
  input logic                  idDrive,
  input logic                  noClaim,
  input logic [NUM_SLICES-1:0] grantVec
);
  // R5: never more than one claimant
  a_r5_single_claim: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));

  // R2: a raised request line always finds a claimant
  a_r2_claim_on_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && irqOut) |-> idDrive);

  // R4: during an acknowledge exactly one of claim or no-claim
  a_r4_claim_or_none: assert property (@(posedge clk) disable iff (!rst_n)
    ackIn |-> (idDrive != noClaim));

  // R8: quiet bus outside an acknowledge
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ackIn |-> (!idDrive && !noClaim && idBus == '0));

  // R7: nothing changes the winner while the acknowledge stays high
  a_r7_frozen_winner: assert property (@(posedge clk) disable iff (!rst_n)
    (ackIn && $past(ackIn)) |-> ($stable(idBus) && $stable(irqOut)));
endmodule

bind irq_chain irq_chain_chk #(
  .NUM_SLICES (NUM_SLICES),
  .ID_W       (ID_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ackIn    (ackIn),
  .irqOut   (irqOut),
  .idBus    (idBus),
  .idDrive  (idDrive),
  .noClaim  (noClaim),
  .grantVec (grantVec)
);

// File: tb/test_irq_chain.sv
`timescale 1ns/1ps
module test_irq_chain;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam logic [N*W-1:0] IDS = 32'h3C_91_D4_6B;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] reqIn = '0;
  logic         ackIn = 1'b0;
  logic         irqOut;
  logic [W-1:0] idBus;
  logic         idDrive;
  logic         noClaim;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  irq_chain #(.NUM_SLICES(N), .ID_W(W), .SLICE_IDS(IDS)) i_irq_chain (
    .clk(clk), .rst_n(rst_n), .reqIn(reqIn), .ackIn(ackIn),
    .irqOut(irqOut), .idBus(idBus), .idDrive(idDrive), .noClaim(noClaim)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lowIdx(input logic [N-1:0] m);
    for (int k = N - 1; k >= 0; k--) if (m[k]) lowIdx = k;
    if (m == '0) lowIdx = -1;
  endfunction

  function automatic logic [W-1:0] idOf(input int k);
    return IDS[k*W +: W];
  endfunction

  // Drive a request mask for one edge, then check the request line (R1).
  task automatic post(input logic [N-1:0] m, input logic [N-1:0] expMask);
    @(negedge clk) reqIn = m;
    @(negedge clk) reqIn = '0;
    #1 check("R1 irqOut after request", irqOut, expMask != '0);
  endtask

  // One acknowledge pulse of one cycle with checks of the claim (R2 R3 R4 R6).
  task automatic serve(inout logic [N-1:0] model);
    int w;
    w = lowIdx(model);
    @(negedge clk) ackIn = 1'b1;
    #1;
    if (w < 0) begin
      check("R4 noClaim", noClaim, 1);
      check("R4 idDrive", idDrive, 0);
      check("R4 idBus", idBus, 0);
    end else begin
      check("R2 idDrive", idDrive, 1);
      check("R2 R3 idBus winner", idBus, idOf(w));
      check("R4 noClaim low", noClaim, 0);
      model[w] = 1'b0;
    end
    @(negedge clk) ackIn = 1'b0;
    #1 check("R8 idle after ack", {idDrive, noClaim, idBus}, 0);
    @(negedge clk);
    #1 check("R6 irqOut after retire", irqOut, model != '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [N-1:0] model;
    repeat (3) @(negedge clk);
    #1 check("R9 irqOut in reset", irqOut, 0);
    check("R8 idle in reset", {idDrive, noClaim, idBus}, 0);
    @(negedge clk) rst_n = 1'b1;
    #1 check("R9 irqOut after reset", irqOut, 0);

    // Exhaustive sweep of every pending pattern, served down to empty.
    for (int p = 0; p < (1 << N); p++) begin
      model = p[N-1:0];
      post(model, model);
      for (int s = 0; s <= N; s++) serve(model);
    end

    // R7: a request during the acknowledge is parked.
    model = 4'b0100;
    post(model, model);
    @(negedge clk) ackIn = 1'b1; reqIn = 4'b0001;
    #1 check("R7 winner unchanged", idBus, idOf(2));
    @(negedge clk) reqIn = '0;
    #1 check("R7 winner still unchanged", idBus, idOf(2));
    check("R7 irqOut held", irqOut, 1);
    @(negedge clk) ackIn = 1'b0;
    @(negedge clk);
    #1 check("R7 parked request pending", irqOut, 1);
    model = 4'b0001;
    serve(model);

    // R10: a new request on the retiring edge keeps the slice pending.
    model = 4'b0010;
    post(model, model);
    @(negedge clk) ackIn = 1'b1;
    #1 check("R10 first claim", idBus, idOf(1));
    @(negedge clk) ackIn = 1'b0; reqIn = 4'b0010;
    @(negedge clk) reqIn = '0;
    #1 check("R10 slice still pending", irqOut, 1);
    serve(model);

    // R9: reset mid-run drops pending requests.
    post(4'b1010, 4'b1010);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    #1 check("R9 reset clears pending", irqOut, 0);
    model = '0;
    serve(model);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule